// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It walks a two-level page table that sits in main memory. The logical address is cut, from the top bit down, into a 10-bit outer index, a 10-bit inner index and a 12-bit page offset. The walker first reads the outer entry. Its address is the table base register plus four times the outer index. The frame field of that entry locates the inner table, and the walker reads the inner entry from it. It checks the inner entry and then joins the inner frame number with the untouched offset.

A length register limits the page numbers that may be used. A reference at or above that limit is refused at once, without any memory read. Each entry holds a valid flag and three access flags: read, write and execute. A failed check ends the walk with one of three trap codes. Software loads the base and the length through a write port that only acts when the privilege input is set. Switching address spaces means rewriting the base register alone.

Requests arrive one at a time through a valid/ready handshake. Entries are fetched through a read port with a request/grant step and a response of any latency. Each walk ends with a one-cycle done pulse carrying the physical address or the trap code.

Top module: `ptw_top`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and mem_req_valid is 0. The length register resets to 0, so every reference ends in the bounds trap until software loads a length.
- R2: The first read goes to base + 4*vaddr[31:22]. The second read goes to {outer entry[31:12], 12'h000} + 4*vaddr[21:12]. A successful walk makes exactly these two reads.
- R3: If the inner entry passes every check, the walk ends with trap code 0 and paddr = {inner entry[31:12], vaddr[11:0]}.
- R4: If vaddr[31:12] is greater than or equal to the length register, the walk ends with trap code 1 (bounds). done rises in the cycle right after the accepting edge, no memory read is made, and paddr reads 0 with any trap code.
- R5: An outer entry whose bit 0 (valid) is 0 ends the walk with trap code 2 (invalid) after one read only.
- R6: An inner entry whose bit 0 (valid) is 0 ends the walk with trap code 2.
- R7: The access kind req_kind is encoded as 0 read, 1 write, 2 execute and 3 reserved. Kind 0 needs inner bit 1, kind 1 needs inner bit 2 and kind 2 needs inner bit 3. Kind 3 is never allowed. If the needed bit is missing, the walk ends with trap code 3 (protection). The valid check takes priority over this check.
- R8: req_ready is 1 only while no walk is in progress. done is a single-cycle pulse, and trap and paddr are meaningful while done is 1.
- R9: mem_req_valid stays high with a stable mem_req_addr until a cycle with mem_req_ready high. The entry is taken in the first later cycle with mem_rsp_valid high, whatever the grant and response delays.
- R10: A write with cfg_we=1 and cfg_priv=1 loads the base register (cfg_sel=0) or the length register (cfg_sel=1, low 21 bits). A write with cfg_priv=0 has no effect.
- R11: A walk uses the base and length in force when its request is accepted. A write in the same cycle as the acceptance applies from the next request on, so rewriting the base switches the address space for later walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_priv | input | 1 | Privilege qualifier for the write |
| cfg_sel | input | 1 | 0 selects the base register, 1 selects the length register |
| cfg_wdata | input | 32 | Register write value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Logical address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory grant for the read request |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Returned entry |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 2 | 0 none, 1 bounds, 2 invalid, 3 protection |
| paddr | output | 32 | Physical address (0 when trapped) |

## Verification
A register write and the acceptance of a translation request can land on the same clock edge. The question is then whether the walk sees the old base and length or the new ones. The bench provokes this in two cases. It drives a privileged base write in the very cycle a request is handshaken, and it drives a length write that would newly forbid the page in that same cycle. It judges the result against a reference model that applies the new value only from the next request. The in-flight walk must still read through the old table and finish with its old translation. The following request must read through the new table, or trap for bounds.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    TRAP_NONE    = 2'd0,
    TRAP_BOUNDS  = 2'd1,
    TRAP_INVALID = 2'd2,
    TRAP_PROT    = 2'd3
  } trap_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_RESP
  } walk_st_e;

  // entry flag positions; the read/write/execute flags follow each other
  localparam int PTE_V_BIT = 0;
  localparam int PTE_R_BIT = 1;
  localparam int N_PERM    = 3;

endpackage

// File: rtl/ptw_cfg_regs.sv
module ptw_cfg_regs #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_priv,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] tbl_base,
  output logic [LEN_W-1:0]  tbl_len,
  output logic              cfg_commit
);

  assign cfg_commit = cfg_we & cfg_priv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_base <= '0;
      tbl_len  <= '0;
    end else if (cfg_commit) begin
      if (cfg_sel) tbl_len  <= cfg_wdata[LEN_W-1:0];
      else         tbl_base <= cfg_wdata;
    end
  end

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
#(
  parameter int PTE_W  = 32,
  parameter int N_KIND = 4,
  localparam int KIND_W = $clog2(N_KIND)
) (
  input  logic [PTE_W-1:0]  pte,
  input  logic [KIND_W-1:0] kind,
  input  logic              at_leaf,
  output logic              pte_invalid,
  output logic              pte_denied
);

  logic [N_KIND-1:0] allow;

  for (genvar k = 0; k < N_KIND; k++) begin : g_kind
    if (k < N_PERM) begin : g_perm
      assign allow[k] = pte[PTE_R_BIT + k];
    end else begin : g_rsvd
      assign allow[k] = 1'b0;
    end
  end

  assign pte_invalid = ~pte[PTE_V_BIT];
  assign pte_denied  = at_leaf & pte[PTE_V_BIT] & ~allow[kind];

endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int LEN_W  = 21,
  parameter int KIND_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [KIND_W-1:0] req_kind,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [LEN_W-1:0]  tbl_len,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  input  logic              chk_invalid,
  input  logic              chk_denied,
  output logic              at_leaf,
  output logic [KIND_W-1:0] kind_q,
  output logic              done,
  output logic [1:0]        trap,
  output logic [ADDR_W-1:0] paddr,
  output logic              ev_bounds,
  output logic              ev_invalid,
  output logic              ev_prot,
  output logic              ev_ok,
  output logic [ADDR_W-1:0] vaddr_q
);

  localparam int VPN_W  = ADDR_W - OFF_W;
  localparam int ENT_SH = 2;

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [ADDR_W-1:0] tbl,
                                                   input logic [ADDR_W-1:0] idx);
    entry_addr = tbl + (idx << ENT_SH);
  endfunction

  function automatic logic [ADDR_W-1:0] frame_base(input logic [ADDR_W-1:0] pte);
    frame_base = {pte[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] join_phys(input logic [ADDR_W-1:0] pte,
                                                  input logic [OFF_W-1:0]  off);
    join_phys = {pte[ADDR_W-1:OFF_W], off};
  endfunction

  walk_st_e          state_q;
  logic [ADDR_W-1:0] next_addr_q;
  trap_e             res_trap_q;
  logic [ADDR_W-1:0] res_paddr_q;

  logic accept;
  logic bounds_fail;
  logic rsp_l1;
  logic rsp_l2;
  logic [ADDR_W-1:0] outer_idx;
  logic [ADDR_W-1:0] inner_idx;

  assign req_ready     = (state_q == ST_IDLE);
  assign accept        = req_valid & req_ready;
  assign bounds_fail   = (LEN_W'(req_vaddr[ADDR_W-1:OFF_W]) >= tbl_len);
  assign outer_idx     = ADDR_W'(req_vaddr[ADDR_W-1:OFF_W+IDX_W]);
  assign inner_idx     = ADDR_W'(vaddr_q[OFF_W+IDX_W-1:OFF_W]);
  assign mem_req_valid = (state_q == ST_L1_REQ) | (state_q == ST_L2_REQ);
  assign mem_req_addr  = next_addr_q;
  assign at_leaf       = (state_q == ST_L2_WAIT);
  assign rsp_l1        = (state_q == ST_L1_WAIT) & mem_rsp_valid;
  assign rsp_l2        = (state_q == ST_L2_WAIT) & mem_rsp_valid;
  assign done          = (state_q == ST_RESP);
  assign trap          = res_trap_q;
  assign paddr         = res_paddr_q;

  assign ev_bounds  = accept & bounds_fail;
  assign ev_invalid = (rsp_l1 | rsp_l2) & chk_invalid;
  assign ev_prot    = rsp_l2 & chk_denied;
  assign ev_ok      = rsp_l2 & ~chk_invalid & ~chk_denied;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      next_addr_q <= '0;
      res_trap_q  <= TRAP_NONE;
      res_paddr_q <= '0;
      vaddr_q     <= '0;
      kind_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            vaddr_q     <= req_vaddr;
            kind_q      <= req_kind;
            next_addr_q <= entry_addr(tbl_base, outer_idx);
            if (bounds_fail) begin
              res_trap_q  <= TRAP_BOUNDS;
              res_paddr_q <= '0;
              state_q     <= ST_RESP;
            end else begin
              state_q <= ST_L1_REQ;
            end
          end
        end
        ST_L1_REQ: if (mem_req_ready) state_q <= ST_L1_WAIT;
        ST_L1_WAIT: begin
          if (mem_rsp_valid) begin
            if (chk_invalid) begin
              res_trap_q  <= TRAP_INVALID;
              res_paddr_q <= '0;
              state_q     <= ST_RESP;
            end else begin
              next_addr_q <= entry_addr(frame_base(mem_rsp_data), inner_idx);
              state_q     <= ST_L2_REQ;
            end
          end
        end
        ST_L2_REQ: if (mem_req_ready) state_q <= ST_L2_WAIT;
        ST_L2_WAIT: begin
          if (mem_rsp_valid) begin
            state_q <= ST_RESP;
            if (chk_invalid) begin
              res_trap_q  <= TRAP_INVALID;
              res_paddr_q <= '0;
            end else if (chk_denied) begin
              res_trap_q  <= TRAP_PROT;
              res_paddr_q <= '0;
            end else begin
              res_trap_q  <= TRAP_NONE;
              res_paddr_q <= join_phys(mem_rsp_data, vaddr_q[OFF_W-1:0]);
            end
          end
        end
        ST_RESP:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ptw_top.sv
module ptw_top #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_priv,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_kind,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done,
  output logic [1:0]        trap,
  output logic [ADDR_W-1:0] paddr
);

  localparam int LEN_W  = ADDR_W - OFF_W + 1;
  localparam int N_KIND = 4;
  localparam int KIND_W = $clog2(N_KIND);

  logic [ADDR_W-1:0] tbl_base;
  logic [LEN_W-1:0]  tbl_len;
  logic              cfg_commit;
  logic              chk_invalid;
  logic              chk_denied;
  logic              at_leaf;
  logic [KIND_W-1:0] kind_q;
  logic              ev_bounds;
  logic              ev_invalid;
  logic              ev_prot;
  logic              ev_ok;
  logic [ADDR_W-1:0] vaddr_q;

  ptw_cfg_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_priv   (cfg_priv),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .tbl_base   (tbl_base),
    .tbl_len    (tbl_len),
    .cfg_commit (cfg_commit)
  );

  ptw_pte_check #(.PTE_W(ADDR_W), .N_KIND(N_KIND)) u_chk_pte (
    .pte         (mem_rsp_data),
    .kind        (kind_q),
    .at_leaf     (at_leaf),
    .pte_invalid (chk_invalid),
    .pte_denied  (chk_denied)
  );

  ptw_walk_fsm #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W),
    .LEN_W  (LEN_W),
    .KIND_W (KIND_W)
  ) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_kind      (req_kind),
    .req_ready     (req_ready),
    .tbl_base      (tbl_base),
    .tbl_len       (tbl_len),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .chk_invalid   (chk_invalid),
    .chk_denied    (chk_denied),
    .at_leaf       (at_leaf),
    .kind_q        (kind_q),
    .done          (done),
    .trap          (trap),
    .paddr         (paddr),
    .ev_bounds     (ev_bounds),
    .ev_invalid    (ev_invalid),
    .ev_prot       (ev_prot),
    .ev_ok         (ev_ok),
    .vaddr_q       (vaddr_q)
  );

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              done,
  input logic [1:0]        trap,
  input logic [ADDR_W-1:0] paddr,
  input logic              ev_bounds,
  input logic              ev_invalid,
  input logic              ev_prot,
  input logic              ev_ok,
  input logic [ADDR_W-1:0] vaddr_q
);

  // R9
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R4
  bounds_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bounds |=> done && (trap == 2'd1) && !mem_req_valid);

  // R3
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (trap == 2'd0) |-> paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]);

  // R7
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_bounds, ev_invalid, ev_prot, ev_ok}));

  // R6
  invalid_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_invalid |=> done && (trap == 2'd2) && (paddr == '0));

  // R7
  prot_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prot |=> done && (trap == 2'd3));

endmodule

bind ptw_top ptw_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptw_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .done          (done),
  .trap          (trap),
  .paddr         (paddr),
  .ev_bounds     (ev_bounds),
  .ev_invalid    (ev_invalid),
  .ev_prot       (ev_prot),
  .ev_ok         (ev_ok),
  .vaddr_q       (vaddr_q)
);

// File: tb/test_ptw_top.sv
`timescale 1ns/1ps
module test_ptw_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_priv = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done;
  logic [1:0]  trap;
  logic [31:0] paddr;

  always #2 clk = ~clk;

  ptw_top i_ptw_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .trap(trap), .paddr(paddr)
  );

  int tests = 0;
  int fails = 0;

  // reference model state
  logic [31:0] mem_model [logic [31:0]];
  logic [31:0] m_base = '0;
  logic [31:0] m_len  = '0;
  logic [31:0] exp_addr [$];
  bit          exp_pending = 1'b0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem_model.exists(a)) return mem_model[a];
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  // memory responder with varying grant and response delays
  int phase = 0, gdly = 0, rdly = 0, seed = 0;
  logic [31:0] cur_addr;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        phase = 0; mem_req_ready = 0; mem_rsp_valid = 0;
      end else begin
        case (phase)
          0: begin
            mem_rsp_valid = 0;
            if (mem_req_valid) begin
              if (gdly == 0) begin
                mem_req_ready = 1;
                cur_addr = mem_req_addr;
                if (exp_addr.size() == 0) begin
                  check("R2 unexpected read", cur_addr, 32'hFFFF_FFFF);
                end else begin
                  check("R2 entry address", cur_addr, exp_addr.pop_front());
                end
                rdly = (seed * 7) % 4;
                phase = 1;
              end else gdly--;
            end
          end
          1: begin
            mem_req_ready = 0;
            if (rdly == 0) begin
              mem_rsp_valid = 1;
              mem_rsp_data = rd(cur_addr);
              phase = 2;
            end else rdly--;
          end
          default: begin
            mem_rsp_valid = 0;
            seed++;
            gdly = seed % 3;
            phase = 0;
          end
        endcase
      end
    end
  end

  // per-clock monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done && !exp_pending) check("R8 stray done", 32'(done), 32'd0);
      if (rst_n && mem_req_valid && req_ready) check("R8 ready while busy", 32'(req_ready), 32'd0);
    end
  end

  task automatic cfg_write(input logic sel, input logic [31:0] val, input logic priv);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = val; cfg_priv = priv;
    @(negedge clk);
    cfg_we = 0; cfg_priv = 0;
    if (priv) begin
      if (sel) m_len = {11'b0, val[20:0]};
      else     m_base = val;
    end
  endtask

  task automatic walk(input string tag, input logic [31:0] va, input logic [1:0] kind,
                      input bit cfg_now, input logic sel, input logic [31:0] val);
    logic [31:0] e1, e2, a1, a2, exp_pa;
    logic [1:0]  exp_tr;
    bit          fast;
    int          cyc;
    exp_pa = 0; fast = 0;
    if ({12'b0, va[31:12]} >= m_len) begin
      exp_tr = 1; fast = 1;
    end else begin
      a1 = m_base + {20'b0, va[31:22], 2'b00};
      exp_addr.push_back(a1);
      e1 = rd(a1);
      if (!e1[0]) exp_tr = 2;
      else begin
        a2 = (e1 & 32'hFFFF_F000) + {20'b0, va[21:12], 2'b00};
        exp_addr.push_back(a2);
        e2 = rd(a2);
        if (!e2[0]) exp_tr = 2;
        else if (kind == 2'd3 || !e2[1 + kind]) exp_tr = 3;
        else begin
          exp_tr = 0; exp_pa = {e2[31:12], va[11:0]};
        end
      end
    end
    @(negedge clk);
    check({tag, " ready before request"}, 32'(req_ready), 32'd1);
    req_valid = 1; req_vaddr = va; req_kind = kind;
    if (cfg_now) begin
      cfg_we = 1; cfg_priv = 1; cfg_sel = sel; cfg_wdata = val;
    end
    exp_pending = 1;
    @(negedge clk);
    req_valid = 0; cfg_we = 0; cfg_priv = 0;
    if (cfg_now) begin
      if (sel) m_len = {11'b0, val[20:0]};
      else     m_base = val;
    end
    cyc = 1;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    if (fast) check({tag, " done latency"}, cyc, 1);
    check({tag, " trap"}, 32'(trap), 32'(exp_tr));
    check({tag, " paddr"}, paddr, exp_pa);
    check({tag, " reads left"}, exp_addr.size(), 0);
    exp_addr.delete();
    @(negedge clk);
    exp_pending = 0;
    check({tag, " done pulse"}, 32'(done), 32'd0);
  endtask

  initial begin
    // table A at 0x10000, table B at 0x30000
    mem_model[32'h0001_0004] = 32'h0002_0001;
    mem_model[32'h0002_000C] = 32'h0034_5003;
    mem_model[32'h0002_0010] = 32'h0034_600F;
    mem_model[32'h0002_0014] = 32'h0034_7000;
    mem_model[32'h0002_0018] = 32'h0034_8009;
    mem_model[32'h0003_0004] = 32'h0004_0001;
    mem_model[32'h0004_000C] = 32'h0077_7003;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req_ready", 32'(req_ready), 32'd1);
    check("R1 done", 32'(done), 32'd0);
    check("R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R1 R4 length is zero after reset
    walk("R1 R4 reset length", 32'h0040_3ABC, 2'd0, 0, 0, 0);

    // R10 privileged loads
    cfg_write(0, 32'h0001_0000, 1);
    cfg_write(1, 32'h0000_1000, 1);

    // R3 R2 normal translation
    walk("R3 read ok", 32'h0040_3ABC, 2'd0, 0, 0, 0);
    walk("R3 write ok", 32'h0040_4123, 2'd1, 0, 0, 0);
    walk("R3 exec ok", 32'h0040_4FFF, 2'd2, 0, 0, 0);
    walk("R3 exec page", 32'h0040_6FFF, 2'd2, 0, 0, 0);
    // R7 protection
    walk("R7 write to read-only", 32'h0040_3000, 2'd1, 0, 0, 0);
    walk("R7 exec denied", 32'h0040_3010, 2'd2, 0, 0, 0);
    walk("R7 read denied", 32'h0040_6000, 2'd0, 0, 0, 0);
    walk("R7 reserved kind", 32'h0040_4000, 2'd3, 0, 0, 0);
    // R6 invalid leaf, checked before permission
    walk("R6 invalid inner", 32'h0040_5000, 2'd3, 0, 0, 0);
    // R5 invalid outer, single read
    walk("R5 invalid outer", 32'h0080_0000, 2'd0, 0, 0, 0);
    // R4 boundaries
    walk("R4 last legal page", 32'h00FF_F000, 2'd0, 0, 0, 0);
    walk("R4 first illegal page", 32'h0100_0000, 2'd0, 0, 0, 0);

    // R10 unprivileged write ignored
    cfg_write(1, 32'h0, 0);
    cfg_write(0, 32'h0003_0000, 0);
    walk("R10 unpriv ignored", 32'h0040_3ABC, 2'd0, 0, 0, 0);

    // R11 base write in the acceptance cycle
    walk("R11 base same cycle", 32'h0040_3ABC, 2'd0, 1, 0, 32'h0003_0000);
    walk("R11 new space", 32'h0040_3ABC, 2'd0, 0, 0, 0);
    // R11 length write in the acceptance cycle
    walk("R11 len same cycle", 32'h0040_3ABC, 2'd0, 1, 1, 32'h0000_0001);
    walk("R11 len applied", 32'h0040_3ABC, 2'd0, 0, 0, 0);

    // R4 full-range length, R9 varied latencies along the way
    cfg_write(1, 32'h0010_0000, 1);
    walk("R4 R9 top page", 32'hFFFF_F000, 2'd0, 0, 0, 0);
    cfg_write(0, 32'h0001_0000, 1);
    walk("R9 R3 back to space A", 32'h0040_4123, 2'd1, 0, 0, 0);

    finish_run();
  end

endmodule